// File: doc/BRIEF.md
# Streaming Operand Register Front-End

This block is the bus-facing register layer of a multi-word modular exponentiation engine. A host reaches it through a simple chip-select bus with a 12-bit address and 32-bit data, where the upper four address bits select a page and only page 0 is decoded. It provides two identification words and a version word, a control register that launches the arithmetic core, a status register that shows whether the core is idle, and three length registers.

Operands do not sit in a directly addressed memory window. Each operand (modulus, exponent, message, result) has two addresses: a pointer-reset port and a data port. Every access to a data port moves that operand's pointer forward by one word. Operands are loaded most significant word first. The modulus and exponent buffers can be read by the core through a word-index port. A stub stands in for the arithmetic core: once launched, it copies the first message-length words of the message buffer into the result buffer, one word per cycle. The block keeps a residue-valid flag. Any change to the modulus or to the modulus length clears this flag, so the core knows to rebuild its cached residue.

Top module: `opx_port_regs`

## Requirements
- R1: After reset, `rdata` is 0, `core_start` is 0, `ready` is 1 and `residue_valid` is 0.
- R2: Reads at 0x000, 0x001 and 0x002 return ID_WORD0, ID_WORD1 and VERSION. Writes to these addresses change nothing.
- R3: Read data appears on `rdata` one cycle after the read is presented. A read of any address with a non-zero page (addr[11:8]) returns 0, and so does a read of any undecoded page-0 address.
- R4: Writing a value with bit 0 set to 0x008 while `ready` is 1 raises `core_start` for exactly one cycle, in the cycle after the write. Writing 0 raises nothing.
- R5: Bit 0 of the status word at 0x009 mirrors `ready`. It is 0 from the start pulse until the copy finishes, which takes one cycle per message word, and 1 otherwise.
- R6: The modulus, exponent and message lengths sit at 0x020, 0x021 and 0x022 respectively. Each read returns the written value in its low 8 bits, with the upper bits reading 0.
- R7: A write of any data to 0x030, 0x040, 0x050 or 0x060 sets the pointer of the modulus, exponent, message or result operand, respectively, to word 0.
- R8: A write to 0x031, 0x041 or 0x051 stores the data at that operand's pointer and then increments the pointer. The pointer is 8 bits wide and wraps from 255 to 0. Writes on a non-zero page are ignored.
- R9: A read of 0x061 returns the result word at the result pointer and then increments the pointer. A write to 0x061 changes no result word.
- R10: A write to 0x031 or 0x020 clears `residue_valid`. A start pulse sets it one cycle later. No other access changes it.
- R11: After a run with message length L, result word i equals message word i for every i < L.
- R12: `core_mod_word` and `core_exp_word` return the modulus and exponent words stored at index `core_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Bus access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Page (11:8) and register (7:0) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| core_start | output | 1 | One-cycle launch pulse to the core |
| ready | output | 1 | Core idle or finished |
| residue_valid | output | 1 | Cached residue matches current modulus |
| core_idx | input | 8 | Core word index into modulus/exponent buffers |
| core_mod_word | output | 32 | Modulus word at core_idx |
| core_exp_word | output | 32 | Exponent word at core_idx |

## Verification
The bench loads 257 message words through the message data port to reach the wrap corner. A pointer that saturates or grows wider would leave word 0 unchanged after the 257th write. It then checks that residue_valid falls after both a modulus word write and a modulus length write, but not after an exponent length write. A design that missed the length case would let the core reuse a stale residue. Other checks confirm that a write to the result data port and accesses on non-zero pages leave stored words intact, and that a start issued while the core is busy is dropped. Random rounds vary the message length and contents, and also read back modulus words through the core port.

// File: rtl/opx_port_regs.sv
module opx_port_regs #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter logic [DW-1:0] ID_WORD0 = 32'h6f707870,
  parameter logic [DW-1:0] ID_WORD1 = 32'h72656773,
  parameter logic [DW-1:0] VERSION  = 32'h00010000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          we,
  input  logic [11:0]   addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          core_start,
  output logic          ready,
  output logic          residue_valid,
  input  logic [AW-1:0] core_idx,
  output logic [DW-1:0] core_mod_word,
  output logic [DW-1:0] core_exp_word
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mod_mem [DEPTH];
  logic [DW-1:0] exp_mem [DEPTH];
  logic [DW-1:0] msg_mem [DEPTH];
  logic [DW-1:0] res_mem [DEPTH];
  logic [AW-1:0] mod_ptr, exp_ptr, msg_ptr, res_ptr;
  logic [AW-1:0] len_mod, len_exp, len_msg;
  logic [AW-1:0] cnt;
  logic          busy;
  logic [DW-1:0] rd_mux;

  wire       pg0  = (addr[11:8] == 4'h0);
  wire       wr   = cs & we & pg0;
  wire       rd   = cs & ~we & pg0;
  wire [7:0] ra   = addr[7:0];
  wire       kick = wr & (ra == 8'h08) & wdata[0] & ready;

  assign ready         = ~busy & ~core_start;
  assign core_mod_word = mod_mem[core_idx];
  assign core_exp_word = exp_mem[core_idx];

  always_comb begin
    case (ra)
      8'h00:   rd_mux = ID_WORD0;
      8'h01:   rd_mux = ID_WORD1;
      8'h02:   rd_mux = VERSION;
      8'h09:   rd_mux = DW'(ready);
      8'h20:   rd_mux = DW'(len_mod);
      8'h21:   rd_mux = DW'(len_exp);
      8'h22:   rd_mux = DW'(len_msg);
      8'h61:   rd_mux = res_mem[res_ptr];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr && ra == 8'h31) mod_mem[mod_ptr] <= wdata;
    if (wr && ra == 8'h41) exp_mem[exp_ptr] <= wdata;
    if (wr && ra == 8'h51) msg_mem[msg_ptr] <= wdata;
    if (busy) res_mem[cnt] <= msg_mem[cnt];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      mod_ptr <= '0; exp_ptr <= '0; msg_ptr <= '0; res_ptr <= '0;
      len_mod <= '0; len_exp <= '0; len_msg <= '0;
      core_start <= 1'b0;
      residue_valid <= 1'b0;
      busy <= 1'b0;
      cnt <= '0;
    end else begin
      rdata <= rd ? rd_mux : '0;
      core_start <= kick;
      if (wr) begin
        case (ra)
          8'h20: len_mod <= wdata[AW-1:0];
          8'h21: len_exp <= wdata[AW-1:0];
          8'h22: len_msg <= wdata[AW-1:0];
          8'h30: mod_ptr <= '0;
          8'h31: mod_ptr <= mod_ptr + 1'b1;
          8'h40: exp_ptr <= '0;
          8'h41: exp_ptr <= exp_ptr + 1'b1;
          8'h50: msg_ptr <= '0;
          8'h51: msg_ptr <= msg_ptr + 1'b1;
          8'h60: res_ptr <= '0;
          default: ;
        endcase
      end
      if (rd && ra == 8'h61) res_ptr <= res_ptr + 1'b1;
      if (wr && (ra == 8'h31 || ra == 8'h20)) residue_valid <= 1'b0;
      else if (core_start) residue_valid <= 1'b1;
      if (core_start) begin
        busy <= (len_msg != '0);
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == len_msg - 1'b1) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/opx_port_regs_chk.sv
module opx_port_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs,
  input logic        we,
  input logic [11:0] addr,
  input logic [31:0] rdata,
  input logic        core_start,
  input logic        ready,
  input logic        residue_valid
);
  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !ready);
  // R10
  residue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && (addr == 12'h031 || addr == 12'h020)) |=> !residue_valid);
  // R10
  residue_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(residue_valid) |-> $past(core_start));
  // R3
  page_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && addr[11:8] != 4'h0) |=> rdata == 32'h0);
endmodule

bind opx_port_regs opx_port_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .rdata(rdata),
  .core_start(core_start), .ready(ready), .residue_valid(residue_valid)
);

// File: tb/sim_opx_port_regs.sv
module sim_opx_port_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, cs = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, core_mod_word, core_exp_word;
  logic        core_start, ready, residue_valid;
  logic [7:0]  core_idx = '0;
  logic [31:0] rd_val;
  logic [31:0] msg_model [256];
  int          n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opx_port_regs u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic brd(input logic [11:0] a);
    @(negedge clk); cs = 1; we = 0; addr = a;
    @(negedge clk); rd_val = rdata; cs = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000; i++) begin
      brd(12'h009);
      if (rd_val[0]) return;
    end
    chk("R5 ready timeout", 32'h0, 32'h1);
  endtask

  function automatic logic [31:0] pat(input int i, input int s);
    return 32'hA5000000 ^ (i * 32'h01010101) ^ s;
  endfunction

  task automatic load_msg(input int n, input int s);
    bwr(12'h050, 32'hFFFF);
    for (int i = 0; i < n; i++) begin
      msg_model[i] = (s < 0) ? $urandom : pat(i, s);
      bwr(12'h051, msg_model[i]);
    end
  endtask

  task automatic run_and_check(input int n, input string req);
    bwr(12'h022, n);
    bwr(12'h008, 1);
    wait_ready();
    bwr(12'h060, 0);
    for (int i = 0; i < n; i++) begin
      brd(12'h061);
      chk(req, rd_val, msg_model[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 0);
    chk("R1 ready", ready, 1);
    chk("R1 residue", residue_valid, 0);
    chk("R1 start", core_start, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after release", ready, 1);

    brd(12'h000); chk("R2 id0", rd_val, 32'h6f707870);
    brd(12'h001); chk("R2 id1", rd_val, 32'h72656773);
    bwr(12'h002, 32'h12345678);
    brd(12'h002); chk("R2 version unchanged", rd_val, 32'h00010000);
    brd(12'h100); chk("R3 page1 read", rd_val, 0);
    brd(12'h0F7); chk("R3 unmapped read", rd_val, 0);
    @(negedge clk); chk("R3 idle rdata", rdata, 0);

    bwr(12'h020, 32'hFFFF_FF05); brd(12'h020); chk("R6 mod len", rd_val, 32'h05);
    bwr(12'h021, 32'h0000_0102); brd(12'h021); chk("R6 exp len", rd_val, 32'h02);

    bwr(12'h008, 0); chk("R4 zero write no pulse", core_start, 0);
    bwr(12'h022, 0);
    bwr(12'h008, 1); chk("R4 pulse", core_start, 1);
    @(negedge clk); chk("R4 pulse one cycle", core_start, 0);
    chk("R10 set by start", residue_valid, 1);
    bwr(12'h021, 3); chk("R10 exp len keeps", residue_valid, 1);
    bwr(12'h030, 0); chk("R10 mod ptr reset keeps", residue_valid, 1);
    bwr(12'h020, 1); chk("R10 mod len clears", residue_valid, 0);
    bwr(12'h008, 1); @(negedge clk); chk("R10 set again", residue_valid, 1);

    bwr(12'h030, 0);
    bwr(12'h031, 32'hCAFE0001); chk("R10 mod word clears", residue_valid, 0);
    bwr(12'h031, 32'hCAFE0002);
    bwr(12'h131, 32'hDEAD0000);
    bwr(12'h031, 32'hCAFE0003);
    core_idx = 0; #1 chk("R12 mod word0", core_mod_word, 32'hCAFE0001);
    core_idx = 2; #1 chk("R8 page1 write ignored", core_mod_word, 32'hCAFE0003);
    bwr(12'h040, 0);
    bwr(12'h041, 32'hBEEF0000); bwr(12'h041, 32'hBEEF0001);
    bwr(12'h040, 0); bwr(12'h041, 32'hBEEF0009);
    core_idx = 0; #1 chk("R7 exp ptr reset", core_exp_word, 32'hBEEF0009);
    core_idx = 1; #1 chk("R12 exp word1", core_exp_word, 32'hBEEF0001);

    load_msg(10, 7);
    bwr(12'h022, 10);
    bwr(12'h008, 1);
    brd(12'h009); chk("R5 busy status", rd_val, 0);
    bwr(12'h022, 10);
    bwr(12'h008, 1);
    wait_ready();
    @(negedge clk); chk("R4 start while busy dropped", core_start, 0);
    chk("R5 ready after copy", ready, 1);
    bwr(12'h060, 0);
    for (int i = 0; i < 10; i++) begin
      brd(12'h061); chk("R11 copy word", rd_val, msg_model[i]);
    end
    bwr(12'h060, 0);
    bwr(12'h061, 32'h0BAD0BAD);
    bwr(12'h060, 0);
    brd(12'h061); chk("R9 result write ignored", rd_val, msg_model[0]);
    brd(12'h061); chk("R9 result ptr advances", rd_val, msg_model[1]);

    bwr(12'h050, 0);
    for (int i = 0; i < 257; i++) bwr(12'h051, 32'h100 + i);
    msg_model[0] = 32'h200; msg_model[1] = 32'h101;
    run_and_check(2, "R8 pointer wrap");

    for (int r = 0; r < 16; r++) begin
      int n = 1 + ($urandom % 12);
      load_msg(n, -1);
      run_and_check(n, "R11 random copy");
      chk("R10 valid after run", residue_valid, 1);
      bwr(12'h030, 0);
      for (int k = 0; k < 3; k++) begin
        logic [31:0] w = $urandom;
        bwr(12'h031, w);
        core_idx = k[7:0]; #1 chk("R12 random mod", core_mod_word, w);
      end
      chk("R10 cleared by mod write", residue_valid, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule